// File: doc/BRIEF.md
# Programmable Pattern Majority Vote

This block sits beside one stored pattern of an associative memory. Each clock it receives a map with one bit per detector layer, set where that layer has fired for this pattern. It decides whether the pattern counts as found. The decision follows a threshold on the number of layers that did not fire. It can also insist that layer 0 has fired. Two global override lines can force a match or suppress one.

Each pattern also keeps one disable bit, written through a word line together with set and clear strobes. The bit masks a pattern known to be faulty. The vote result and a copy of the layer map are captured into output registers on cycles where the read flag is high.

A small decoder, part of the same module, turns a 3-bit threshold code into the five configuration lines that the vote uses. Those lines are also brought out as outputs.

Top module: `pattern_vote`

## Requirements
- R1: While `init` is high at a rising edge, `match_q`, `map_q` and the stored disable bit are all cleared at that edge.
- R2: Threshold code `opcode[1:0]`=00 means matching is off: without `force_rd`, `match_q` is captured as 0.
- R3: Code 01 allows no missing layer: a match needs all 8 bits of `layer_hit` set. The miss count is 8 minus the number of ones in `layer_hit`.
- R4: Code 10 allows at most one missing layer.
- R5: Code 11 allows at most two missing layers; three or more misses give no match.
- R6: When `opcode[2]` is 1, no match is captured unless `layer_hit[0]` is 1, whatever the miss count, unless `force_rd` is high.
- R7: `force_rd` gives a match whatever the miss count, the layer-0 requirement and the threshold code, unless a blocking condition of R8 or R9 applies.
- R8: `block_rd` high makes the captured match 0, even with `force_rd` high.
- R9: The disable bit is set at an edge where `wl` and `dis_set` are high, and cleared where `wl` and `dis_clr` are high. Clear wins when both strobes are high. Without `wl` the strobes have no effect. While the bit is set, no match is captured, even with `force_rd`. A write takes effect from the following edge.
- R10: `match_q` and `map_q` load only at edges where `rd_flag` is high; `map_q` then takes `layer_hit`. At other edges both hold their value.
- R11: `cfg_lines` is combinational from `opcode`. Its bit 0 is matching-off (code 00), bit 1 is zero-miss (01), bit 2 is one-miss (10), bit 3 is two-miss (11), and bit 4 copies `opcode[2]`. Exactly one of bits 3:0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init | input | 1 | Synchronous clear, active high |
| opcode | input | 3 | [1:0] threshold code, [2] layer-0 requirement |
| force_rd | input | 1 | Force a match |
| block_rd | input | 1 | Suppress any match |
| wl | input | 1 | Word line enabling a disable-bit write |
| dis_set | input | 1 | Set strobe for the disable bit |
| dis_clr | input | 1 | Clear strobe for the disable bit |
| layer_hit | input | 8 | Fired-layer map, one bit per layer |
| rd_flag | input | 1 | Capture enable for the outputs |
| cfg_lines | output | 5 | Decoded configuration lines |
| match_q | output | 1 | Registered pattern match |
| map_q | output | 8 | Registered layer map |

## Verification
The assertions take for granted that the configuration inputs (`opcode`, `force_rd`, `block_rd`) and all other inputs change only shortly after a rising edge and are settled before the next one. They also assume `init` is asserted from time zero. The stimulus drives every input one time unit after the edge and holds it for a full cycle. It starts with two cycles of `init`. Directed runs and a long randomized run then vary the code, the overrides, the word-line strobes and the read flag freely within that timing.

// File: rtl/pattern_vote.sv
module pattern_vote #(
  parameter int NLAYER = 8
) (
  input  logic              clk,
  input  logic              init,
  input  logic [2:0]        opcode,
  input  logic              force_rd,
  input  logic              block_rd,
  input  logic              wl,
  input  logic              dis_set,
  input  logic              dis_clr,
  input  logic [NLAYER-1:0] layer_hit,
  input  logic              rd_flag,
  output logic [4:0]        cfg_lines,
  output logic              match_q,
  output logic [NLAYER-1:0] map_q
);
  localparam int CW = $clog2(NLAYER + 1);

  logic          cfg_off, cfg_m0, cfg_m1, cfg_m2, cfg_need0;
  logic [CW-1:0] hits, miss;
  logic          thr_ok, layer0_ok, vote, dis_q;

  assign cfg_off   = (opcode[1:0] == 2'b00);
  assign cfg_m0    = (opcode[1:0] == 2'b01);
  assign cfg_m1    = (opcode[1:0] == 2'b10);
  assign cfg_m2    = (opcode[1:0] == 2'b11);
  assign cfg_need0 = opcode[2];
  assign cfg_lines = {cfg_need0, cfg_m2, cfg_m1, cfg_m0, cfg_off};

  always_comb begin
    hits = '0;
    for (int i = 0; i < NLAYER; i++) hits = hits + CW'(layer_hit[i]);
  end

  assign miss      = CW'(NLAYER) - hits;
  assign thr_ok    = (cfg_m0 & (miss == '0)) |
                     (cfg_m1 & (miss <= CW'(1))) |
                     (cfg_m2 & (miss <= CW'(2)));
  assign layer0_ok = ~cfg_need0 | layer_hit[0];
  assign vote      = ~block_rd & ~dis_q & (force_rd | (thr_ok & layer0_ok));

  always_ff @(posedge clk) begin
    if (init)                dis_q <= 1'b0;
    else if (wl && dis_clr)  dis_q <= 1'b0;
    else if (wl && dis_set)  dis_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (init) begin
      match_q <= 1'b0;
      map_q   <= '0;
    end else if (rd_flag) begin
      match_q <= vote;
      map_q   <= layer_hit;
    end
  end
endmodule

// File: rtl/pattern_vote_chk.sv
module pattern_vote_chk #(
  parameter int NLAYER = 8
) (
  input logic              clk,
  input logic              init,
  input logic              force_rd,
  input logic              block_rd,
  input logic [NLAYER-1:0] layer_hit,
  input logic              rd_flag,
  input logic [4:0]        cfg_lines,
  input logic              match_q,
  input logic [NLAYER-1:0] map_q,
  input logic              dis_q
);
  assert_init_clears_R1: assert property (@(posedge clk)
    init |=> (!match_q && map_q == '0 && !dis_q));

  assert_hold_without_read_R10: assert property (@(posedge clk) disable iff (init)
    !rd_flag |=> ($stable(match_q) && $stable(map_q)));

  assert_map_capture_R10: assert property (@(posedge clk) disable iff (init)
    rd_flag |=> (map_q == $past(layer_hit)));

  assert_block_wins_R8: assert property (@(posedge clk) disable iff (init)
    (rd_flag && block_rd) |=> !match_q);

  assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (init)
    (rd_flag && dis_q) |=> !match_q);

  assert_force_matches_R7: assert property (@(posedge clk) disable iff (init)
    (rd_flag && force_rd && !block_rd && !dis_q) |=> match_q);

  assert_need_layer0_R6: assert property (@(posedge clk) disable iff (init)
    (rd_flag && cfg_lines[4] && !layer_hit[0] && !force_rd) |=> !match_q);

  assert_one_mode_R11: assert property (@(posedge clk) disable iff (init)
    $countones(cfg_lines[3:0]) == 1);
endmodule

bind pattern_vote pattern_vote_chk #(.NLAYER(NLAYER)) u_chk (
  .clk(clk), .init(init), .force_rd(force_rd), .block_rd(block_rd),
  .layer_hit(layer_hit), .rd_flag(rd_flag), .cfg_lines(cfg_lines),
  .match_q(match_q), .map_q(map_q), .dis_q(dis_q)
);

// File: tb/pattern_vote_tb.sv
module pattern_vote_tb;
  logic       clk = 1'b0;
  logic       init = 1'b1;
  logic [2:0] opcode = '0;
  logic       force_rd = 0, block_rd = 0, wl = 0, dis_set = 0, dis_clr = 0, rd_flag = 0;
  logic [7:0] layer_hit = '0;
  logic [4:0] cfg_lines;
  logic       match_q;
  logic [7:0] map_q;

  int errors = 0, checks = 0;
  bit done = 0;
  bit m_match = 0, m_dis = 0;
  logic [7:0] m_map = '0;

  always #2.5 clk = ~clk;

  pattern_vote u_dut (
    .clk(clk), .init(init), .opcode(opcode), .force_rd(force_rd),
    .block_rd(block_rd), .wl(wl), .dis_set(dis_set), .dis_clr(dis_clr),
    .layer_hit(layer_hit), .rd_flag(rd_flag), .cfg_lines(cfg_lines),
    .match_q(match_q), .map_q(map_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_vote();
    int ones = 0, allowed;
    for (int i = 0; i < 8; i++) ones += layer_hit[i];
    case (opcode[1:0])
      2'b00: allowed = -1;
      2'b01: allowed = 0;
      2'b10: allowed = 1;
      default: allowed = 2;
    endcase
    if (block_rd || m_dis) return 0;
    if (force_rd) return 1;
    if (allowed < 0) return 0;
    if (opcode[2] && !layer_hit[0]) return 0;
    return (8 - ones) <= allowed;
  endfunction

  task automatic tick(input string tag);
    bit v = ref_vote();
    logic [4:0] ecfg;
    @(posedge clk);
    #1;
    if (init) begin
      m_match = 0; m_map = '0; m_dis = 0;
    end else begin
      if (rd_flag) begin m_match = v; m_map = layer_hit; end
      if (wl && dis_clr) m_dis = 0;
      else if (wl && dis_set) m_dis = 1;
    end
    ecfg = {opcode[2], opcode[1:0] == 2'd3, opcode[1:0] == 2'd2,
            opcode[1:0] == 2'd1, opcode[1:0] == 2'd0};
    chk({tag, " match"}, match_q, m_match);
    chk({tag, " map"}, map_q, m_map);
    chk("R11 cfg", cfg_lines, ecfg);
  endtask

  task automatic rd(input logic [2:0] op, input logic [7:0] hit, input bit frc,
                    input bit blk, input string tag);
    opcode = op; layer_hit = hit; force_rd = frc; block_rd = blk; rd_flag = 1;
    tick(tag);
    rd_flag = 0;
  endtask

  task automatic wr(input bit w, input bit s, input bit c, input string tag);
    wl = w; dis_set = s; dis_clr = c;
    tick(tag);
    wl = 0; dis_set = 0; dis_clr = 0;
  endtask

  initial begin
    tick("R1"); tick("R1");
    init = 0;
    rd(3'b000, 8'hFF, 0, 0, "R2 off all hit");
    rd(3'b001, 8'hFF, 0, 0, "R3 zero miss hit");
    rd(3'b001, 8'hFE, 0, 0, "R3 one miss");
    rd(3'b010, 8'hF7, 0, 0, "R4 one miss");
    rd(3'b010, 8'h77, 0, 0, "R4 two miss");
    rd(3'b011, 8'h3F, 0, 0, "R5 two miss");
    rd(3'b011, 8'h1F, 0, 0, "R5 three miss");
    rd(3'b111, 8'hFE, 0, 0, "R6 layer0 missing");
    rd(3'b111, 8'h7F, 0, 0, "R6 layer0 present");
    rd(3'b100, 8'h00, 1, 0, "R7 force code off");
    rd(3'b111, 8'h00, 1, 0, "R7 force no layer0");
    rd(3'b011, 8'hFF, 1, 1, "R8 block over force");
    opcode = 3'b001; layer_hit = 8'h12; tick("R10 hold");
    rd(3'b001, 8'hFF, 0, 0, "R10 capture");
    layer_hit = 8'h00; tick("R10 hold after");
    wr(0, 1, 0, "R9 no wl");
    rd(3'b001, 8'hFF, 0, 0, "R9 still enabled");
    wr(1, 1, 0, "R9 set");
    rd(3'b001, 8'hFF, 1, 0, "R9 disabled beats force");
    wr(1, 1, 1, "R9 clear wins");
    rd(3'b001, 8'hFF, 0, 0, "R9 cleared");
    wr(1, 1, 0, "R9 set again");
    init = 1; tick("R1 clears disable"); init = 0;
    rd(3'b001, 8'hFF, 0, 0, "R1 enabled after init");
    for (int n = 0; n < 4000; n++) begin
      opcode = 3'($urandom); layer_hit = 8'($urandom) | 8'($urandom);
      force_rd = ($urandom % 6) == 0; block_rd = ($urandom % 8) == 0;
      wl = ($urandom % 10) == 0; dis_set = 1'($urandom); dis_clr = 1'($urandom);
      rd_flag = ($urandom % 4) != 0; init = ($urandom % 200) == 0;
      tick("R5 random mix");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule